// File: doc/BRIEF.md
# Bridge Power-State Register and Downstream Gate

This block holds the power management control/status dword of a PCI-to-PCI bridge function and applies its power state to the bridge's traffic. Configuration software reads and writes the dword through a simple single-cycle configuration port. The block keeps a two-bit power state and a sticky PME-enable flag, and it turns the current state into three enables: one for claiming downstream cycles, one for memory-mapped register access and one for interrupt generation.

Only the fully-on state (D0) and the deep-sleep state (D3) are accepted. A write that asks for one of the two intermediate states completes without error, but its state value is thrown away. Outside D0 the bridge claims only type-0 configuration cycles. Any other downstream request is left unclaimed, and a one-cycle master-abort pulse follows it so that an outside status register can log the event.

Top module: `pm_bridge_gate`

## Requirements
- R1: After `rst` or `por`, a read of the register returns 0000_0008h, `pwr_state` is 00 (D0), and `mmio_en` and `irq_en` are 1.
- R2: The register sits at configuration dword index 21h (byte offset 84h). A write there with `cfg_be[0]`=1 and bits 1:0 equal to 00 (D0) or 11 (D3) loads those bits into the power state, and a read returns them in bits 1:0.
- R3: A write with bits 1:0 equal to 01 (D1) or 10 (D2) leaves the power state unchanged.
- R4: A write with `cfg_be[0]`=0 leaves the power state unchanged.
- R5: Bit 8 is the PME-enable flag. A write with `cfg_be[1]`=1 loads it, and it reads back in bit 8. Its value has no effect on `ds_claim`, `mmio_en` or `irq_en`.
- R6: The PME-enable flag keeps its value through `rst` and is cleared only by `por`.
- R7: Bits 31:9 and 7:4 and bit 2 always read 0, and bit 3 always reads 1, whatever value was written.
- R8: While the power state is D3, `ds_claim` is 1 for a request of kind 2 (type-0 configuration) and 0 for kinds 0 (memory), 1 (I/O) and 3 (type-1 configuration). In D0, every request is claimed.
- R9: An unclaimed request in cycle n produces `ds_mabort`=1 in cycle n+1 only. A claimed request produces no pulse.
- R10: `mmio_en` and `irq_en` are 1 in D0 and 0 in D3.
- R11: A power-state write changes the gating starting with the clock cycle after the one in which the write is presented.
- R12: Reads at any other dword index return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Function reset, synchronous, active high; keeps the sticky flag |
| por | input | 1 | Power-on reset, synchronous, active high; clears everything |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid in the cycle of `cfg_rd` |
| ds_req | input | 1 | Downstream request valid |
| ds_kind | input | 2 | Request kind: 0 mem, 1 I/O, 2 type-0 cfg, 3 type-1 cfg |
| ds_claim | output | 1 | Bridge claims the current request |
| ds_mabort | output | 1 | One-cycle pulse after an unclaimed request |
| mmio_en | output | 1 | Memory-mapped register access allowed |
| irq_en | output | 1 | Interrupt generation allowed |
| pwr_state | output | 2 | Current power state |

## Verification
The hardest case to reach is the sticky flag surviving a function reset while the power state underneath it returns to D0. To get there, the bench moves the block to D3 with the flag set, pulses only `rst`, reads the dword back, and then pulses `por` and reads again. A second delicate case is the edge where a state write and a downstream request fall in the same cycle. The bench presents both together and samples `ds_claim` before and after that clock edge, which shows that the gating switches exactly one cycle later.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int DW      = 32;
    localparam int ADDR_W  = 6;
    localparam int BE_W    = DW / 8;

    typedef enum logic [1:0] {
        PM_D0 = 2'b00,
        PM_D1 = 2'b01,
        PM_D2 = 2'b10,
        PM_D3 = 2'b11
    } pm_state_e;

    typedef enum logic [1:0] {
        DK_MEM  = 2'd0,
        DK_IO   = 2'd1,
        DK_CFG0 = 2'd2,
        DK_CFG1 = 2'd3
    } ds_kind_e;

    typedef struct packed {
        logic      valid;
        ds_kind_e  kind;
    } ds_req_t;

    typedef struct packed {
        logic                wr;
        logic                rd;
        logic [ADDR_W-1:0]   addr;
        logic [BE_W-1:0]     be;
        logic [DW-1:0]       wdata;
    } cfg_req_t;

    // Bit positions inside the dword
    localparam int PS_LSB   = 0;
    localparam int NSR_BIT  = 3;
    localparam int PMEE_BIT = 8;

    function automatic logic state_supported(input logic [1:0] s);
        return (s == PM_D0) || (s == PM_D3);
    endfunction

    function automatic logic [DW-1:0] pack_dword(input pm_state_e s, input logic pmee);
        logic [DW-1:0] d;
        d = '0;
        d[PS_LSB +: 2] = s;
        d[NSR_BIT]     = 1'b1;
        d[PMEE_BIT]    = pmee;
        return d;
    endfunction

endpackage

// File: rtl/pm_csr.sv
module pm_csr
    import pm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_IDX = 6'h21
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           por,
    input  cfg_req_t       req,
    output logic [DW-1:0]  rdata,
    output pm_state_e      state
);

    localparam int BE_PS   = PS_LSB / 8;
    localparam int BE_PMEE = PMEE_BIT / 8;

    logic       hit;
    logic       ps_load;
    logic       pmee_q;
    logic [1:0] ps_new;

    assign hit     = (req.addr == REG_IDX);
    assign ps_new  = req.wdata[PS_LSB +: 2];
    assign ps_load = req.wr && hit && req.be[BE_PS] && state_supported(ps_new);

    // Power state: cleared by either reset
    always_ff @(posedge clk) begin
        if (rst || por)
            state <= PM_D0;
        else if (ps_load)
            state <= pm_state_e'(ps_new);
    end

    // Sticky enable: cleared by power-on reset only
    always_ff @(posedge clk) begin
        if (por)
            pmee_q <= 1'b0;
        else if (req.wr && hit && req.be[BE_PMEE])
            pmee_q <= req.wdata[PMEE_BIT];
    end

    always_comb begin
        rdata = '0;
        if (req.rd && hit)
            rdata = pack_dword(state, pmee_q);
    end

    // R3
    bad_state_write_chk: assert property (@(posedge clk) disable iff (rst || por)
        (req.wr && hit && (req.wdata[1:0] == PM_D1 || req.wdata[1:0] == PM_D2))
            |=> $stable(state));

    // R4
    no_be0_chk: assert property (@(posedge clk) disable iff (rst || por)
        (req.wr && !req.be[BE_PS]) |=> $stable(state));

    // R6
    sticky_keep_chk: assert property (@(posedge clk) disable iff (por)
        (rst && !(req.wr && hit && req.be[BE_PMEE])) |=> $stable(pmee_q));

    // R2
    legal_state_chk: assert property (@(posedge clk) disable iff (rst || por)
        (state == PM_D0) || (state == PM_D3));

endmodule

// File: rtl/pm_gate.sv
module pm_gate
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  pm_state_e  state,
    input  ds_req_t    ds,
    output logic       claim,
    output logic       mabort,
    output logic       mmio_en,
    output logic       irq_en
);

    logic awake;
    logic pass_kind;

    assign awake     = (state == PM_D0);
    assign pass_kind = (ds.kind == DK_CFG0);

    assign claim   = ds.valid && (awake || pass_kind);
    assign mmio_en = awake;
    assign irq_en  = awake;

    always_ff @(posedge clk) begin
        if (rst || por)
            mabort <= 1'b0;
        else
            mabort <= ds.valid && !claim;
    end

    // R8
    cfg0_pass_chk: assert property (@(posedge clk) disable iff (rst || por)
        (ds.valid && ds.kind == DK_CFG0) |-> claim);

    // R9
    abort_cause_chk: assert property (@(posedge clk) disable iff (rst || por)
        mabort |-> ($past(ds.valid) && $past(ds.kind) != DK_CFG0 && $past(state) != PM_D0));

    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst || por)
        (state == PM_D3) |-> (!mmio_en && !irq_en));

endmodule

// File: rtl/pm_bridge_gate.sv
module pm_bridge_gate
    import pm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_IDX = 6'h21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              ds_req,
    input  logic [1:0]        ds_kind,
    output logic              ds_claim,
    output logic              ds_mabort,
    output logic              mmio_en,
    output logic              irq_en,
    output logic [1:0]        pwr_state
);

    cfg_req_t  creq;
    ds_req_t   dreq;
    pm_state_e st;

    assign creq = '{wr: cfg_wr, rd: cfg_rd, addr: cfg_addr, be: cfg_be, wdata: cfg_wdata};
    assign dreq = '{valid: ds_req, kind: ds_kind_e'(ds_kind)};

    pm_csr #(.REG_IDX(REG_IDX)) u_csr (
        .clk   (clk),
        .rst   (rst),
        .por   (por),
        .req   (creq),
        .rdata (cfg_rdata),
        .state (st)
    );

    pm_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .por     (por),
        .state   (st),
        .ds      (dreq),
        .claim   (ds_claim),
        .mabort  (ds_mabort),
        .mmio_en (mmio_en),
        .irq_en  (irq_en)
    );

    assign pwr_state = st;

endmodule

// File: tb/sim_pm_bridge_gate.sv
module sim_pm_bridge_gate;

    logic        clk = 1'b0;
    logic        rst, por;
    logic        cfg_wr, cfg_rd;
    logic [5:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        ds_req;
    logic [1:0]  ds_kind;
    logic        ds_claim, ds_mabort, mmio_en, irq_en;
    logic [1:0]  pwr_state;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [5:0] IDX = 6'h21;

    always #2 clk = ~clk;

    pm_bridge_gate u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        cfg_wr = 0; cfg_rd = 0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0;
        ds_req = 0; ds_kind = 2'd0;
    endtask

    task automatic pulse_reset(input bit use_por);
        @(negedge clk);
        rst = !use_por; por = use_por;
        @(negedge clk);
        rst = 0; por = 0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0; cfg_be = '0; cfg_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1; cfg_addr = a;
        #1 d = cfg_rdata;
        cfg_rd = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        pulse_reset(1);
        rd(IDX, d);
        chk("R1 read", d, 32'h0000_0008);
        chk("R1 state", pwr_state, 2'b00);
        chk("R1 enables", {mmio_en, irq_en}, 2'b11);
    endtask

    task automatic t_states();
        logic [31:0] d;
        wr(IDX, 4'b0001, 32'h0000_0003);
        chk("R2 state D3", pwr_state, 2'b11);
        rd(IDX, d);
        chk("R2 read D3", d, 32'h0000_000B);
        chk("R10 D3 enables", {mmio_en, irq_en}, 2'b00);
        wr(IDX, 4'b0001, 32'h0000_0001);
        chk("R3 D1 ignored", pwr_state, 2'b11);
        wr(IDX, 4'b0001, 32'h0000_0000);
        chk("R2 back to D0", pwr_state, 2'b00);
        chk("R10 D0 enables", {mmio_en, irq_en}, 2'b11);
        wr(IDX, 4'b0001, 32'h0000_0002);
        chk("R3 D2 ignored", pwr_state, 2'b00);
        wr(IDX, 4'b1110, 32'h0000_0003);
        chk("R4 no be0", pwr_state, 2'b00);
    endtask

    task automatic t_fields();
        logic [31:0] d;
        wr(IDX, 4'b1111, 32'hFFFF_FFFC);
        rd(IDX, d);
        chk("R7 RO bits", d, 32'h0000_0108);
        chk("R5 pmee no gating", {mmio_en, irq_en}, 2'b11);
        wr(IDX, 4'b0010, 32'h0000_0000);
        rd(IDX, d);
        chk("R5 pmee clear", d, 32'h0000_0008);
        wr(IDX, 4'b0010, 32'h0000_0100);
        wr(IDX, 4'b0001, 32'h0000_0003);
        pulse_reset(0);
        rd(IDX, d);
        chk("R6 sticky through rst", d, 32'h0000_0108);
        pulse_reset(1);
        rd(IDX, d);
        chk("R6 por clears", d, 32'h0000_0008);
    endtask

    task automatic t_other_addr();
        logic [31:0] d;
        rd(6'h20, d);
        chk("R12 read other", d, 32'h0);
        wr(6'h22, 4'b1111, 32'h0000_0103);
        rd(IDX, d);
        chk("R12 write other", d, 32'h0000_0008);
    endtask

    task automatic t_gating();
        wr(IDX, 4'b0011, 32'h0000_0103);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ds_req = 1; ds_kind = 2'(k);
            #1 chk("R8 D3 claim", ds_claim, (k == 2) ? 1'b1 : 1'b0);
            @(negedge clk);
            ds_req = 0;
            #1 chk("R9 abort pulse", ds_mabort, (k == 2) ? 1'b0 : 1'b1);
            @(negedge clk);
            #1 chk("R9 pulse ends", ds_mabort, 1'b0);
        end
        chk("R5 pmee set D3 gate", {mmio_en, irq_en}, 2'b00);
        // R11: write D0 and request together
        @(negedge clk);
        cfg_wr = 1; cfg_addr = IDX; cfg_be = 4'b0001; cfg_wdata = 32'h0;
        ds_req = 1; ds_kind = 2'd0;
        #1 chk("R11 before edge", ds_claim, 1'b0);
        @(negedge clk);
        cfg_wr = 0;
        #1 chk("R11 after edge", ds_claim, 1'b1);
        chk("R9 abort from write cycle", ds_mabort, 1'b1);
        @(negedge clk);
        ds_req = 0;
        #1 chk("R8 D0 no abort", ds_mabort, 1'b0);
        for (int k = 0; k < 4; k++) begin
            ds_req = 1; ds_kind = 2'(k);
            #1 chk("R8 D0 claim", ds_claim, 1'b1);
        end
        ds_req = 0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1; por = 1;
        repeat (2) @(negedge clk);
        rst = 0; por = 0;
        t_reset();
        t_states();
        t_fields();
        t_other_addr();
        t_gating();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule